// File: doc/BRIEF.md
# Per-Core Interrupt and Mailbox Controller

This block collects the interrupt sources that belong to each core of a four-core cluster and presents them on one level-sensitive interrupt line per core. Each core has four raw timer inputs, a 32-bit inter-processor mailbox, a shared graphics fast-interrupt input (delivered to one chosen core) and a shared performance-monitor input that can be steered to any subset of cores. Software reaches the block through a simple single-port 32-bit register bus with a combinational read path and writes that take effect at the next clock edge.

A core posts a message to another core by writing one-bits to the target's mailbox set address. The target reads its mailbox through its clear address and acknowledges by writing the same bits back there. Per-core enables gate the timer inputs and the mailbox, a shared routing register gates the monitor input, and a read-only pending word per core shows what currently drives that core's line. Pending bits are computed from live state every cycle, so nothing has to be acknowledged through the pending word.

Top module: `core_irq_hub`

## Requirements
- R1: While reset is held, and after it, every readable register reads zero and all `irq_out` lines are low.
- R2: A write to core c's mailbox set address (0x40 + 16*c) ORs the written one-bits into that mailbox and leaves its other bits and all other mailboxes unchanged; the set address itself reads zero.
- R3: Reading core c's mailbox clear address (0x80 + 16*c) returns that mailbox; writing it clears exactly the bits written as one.
- R4: Bit 0 of core c's mailbox enable register (0x20 + 4*c) gates the mailbox: pending bit 4 of core c is one only when that bit is set and the mailbox is nonzero.
- R5: Core c's timer enable register (0x10 + 4*c) holds enables in bits 3:0 for the secure physical, non-secure physical, hypervisor physical and virtual timers; pending bit i (i = 0..3) is enable bit i AND raw timer input 4*c+i.
- R6: Writing bit n to the routing set address 0x00 enables monitor delivery to core n and writing bit n to the routing clear address 0x04 disables it, other cores unaffected; both addresses read the routing mask; pending bit 6 of core n is routing bit n AND the monitor input.
- R7: Pending bit 5 follows the graphics fast input on core `GPU_CORE` only and reads zero on every other core.
- R8: `irq_out[c]` is high exactly when core c's pending word (0x30 + 4*c) is nonzero, and stays high until every contributing condition is gone.
- R9: Reads of unmapped addresses return zero; writes to unmapped addresses and to pending words change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timer_raw | input | 16 | Raw timer levels, four per core, core c in bits 4*c+3:4*c |
| gpu_raw | input | 1 | Shared graphics fast-interrupt level |
| pmu_raw | input | 1 | Shared performance-monitor interrupt level |
| irq_out | output | 4 | Interrupt line per core |

## Verification
The assertions assume a single register port, so a set and a clear of the same mailbox or routing mask never land in one cycle, and that bus writes only start once the internal reset release has completed. The stimulus drives one access per cycle on falling clock edges and waits several cycles after each reset release before the first write. Raw source inputs are treated as free-running levels; the assertions only relate them to pending bits, and the bench changes them only between accesses.

// File: rtl/cih_pkg.sv
package cih_pkg;
  // Register offsets (byte addresses); per-core stride is 4 for control
  // and pending words and 16 for mailbox addresses.
  localparam int ROUTE_SET = 'h00;
  localparam int ROUTE_CLR = 'h04;
  localparam int TMR_CTL   = 'h10;
  localparam int MBX_CTL   = 'h20;
  localparam int PEND_BASE = 'h30;
  localparam int MBX_SET   = 'h40;
  localparam int MBX_CLR   = 'h80;
  localparam int CTL_STEP  = 4;
  localparam int MBX_STEP  = 16;

  // Pending word layout
  localparam int NTMR   = 4;
  localparam int PB_MBX = NTMR;
  localparam int PB_GPU = NTMR + 1;
  localparam int PB_PMU = NTMR + 2;
  localparam int PEND_W = NTMR + 3;
endpackage

// File: rtl/cih_mbox.sv
module cih_mbox #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d;
  logic              en;

  always_comb begin
    en = set_we | clr_we;
    d  = q;
    if (set_we) d = d | wdata;
    if (clr_we) d = d & ~wdata;   // clear wins on overlap
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cih_route.sv
module cih_route #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [NCORE-1:0] wbits,
  output logic [NCORE-1:0] q
);
  logic [NCORE-1:0] d;
  logic             en;

  always_comb begin
    en = set_we | clr_we;
    d  = q;
    if (set_we) d = d | wbits;
    if (clr_we) d = d & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cih_core.sv
module cih_core
  import cih_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tc_we,
  input  logic              mc_we,
  input  logic              ms_we,
  input  logic              mclr_we,
  input  logic [NTMR-1:0]   tmr_raw,
  input  logic              gpu_in,
  input  logic              pmu_in,
  output logic [NTMR-1:0]   tmr_en,
  output logic              mbx_en,
  output logic [DATA_W-1:0] mbox,
  output logic [PEND_W-1:0] pend
);
  logic [NTMR-1:0] tmr_en_d;
  logic            mbx_en_d;

  always_comb begin
    tmr_en_d = tc_we ? wdata[NTMR-1:0] : tmr_en;
    mbx_en_d = mc_we ? wdata[0]        : mbx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en <= '0;
      mbx_en <= 1'b0;
    end else begin
      if (tc_we) tmr_en <= tmr_en_d;
      if (mc_we) mbx_en <= mbx_en_d;
    end
  end

  cih_mbox #(.DATA_W(DATA_W)) u_mbox (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (ms_we),
    .clr_we (mclr_we),
    .wdata  (wdata),
    .q      (mbox)
  );

  // Level-sensitive pending word, rebuilt every cycle
  always_comb begin
    pend               = '0;
    pend[NTMR-1:0]     = tmr_en & tmr_raw;
    pend[PB_MBX]       = mbx_en & (|mbox);
    pend[PB_GPU]       = gpu_in;
    pend[PB_PMU]       = pmu_in;
  end
endmodule

// File: rtl/core_irq_hub.sv
module core_irq_hub
  import cih_pkg::*;
#(
  parameter int NCORE    = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int GPU_CORE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [NCORE*NTMR-1:0]  timer_raw,
  input  logic                   gpu_raw,
  input  logic                   pmu_raw,
  output logic [NCORE-1:0]       irq_out
);
  localparam logic [ADDR_W-1:0] A_RSET = ADDR_W'(ROUTE_SET);
  localparam logic [ADDR_W-1:0] A_RCLR = ADDR_W'(ROUTE_CLR);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [NCORE-1:0]        route_q;
  logic [NCORE*DATA_W-1:0] mbox_flat;
  logic [NCORE*PEND_W-1:0] pend_flat;
  logic [NCORE-1:0]        mbx_en_v;
  logic [DATA_W-1:0]       rd_c [NCORE];

  cih_route #(.NCORE(NCORE)) u_route (
    .clk    (clk),
    .rst_n  (rst_q),
    .set_we (bus_we && bus_addr == A_RSET),
    .clr_we (bus_we && bus_addr == A_RCLR),
    .wbits  (bus_wdata[NCORE-1:0]),
    .q      (route_q)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam logic [ADDR_W-1:0] A_TC   = ADDR_W'(TMR_CTL   + CTL_STEP * c);
    localparam logic [ADDR_W-1:0] A_MC   = ADDR_W'(MBX_CTL   + CTL_STEP * c);
    localparam logic [ADDR_W-1:0] A_PD   = ADDR_W'(PEND_BASE + CTL_STEP * c);
    localparam logic [ADDR_W-1:0] A_MS   = ADDR_W'(MBX_SET   + MBX_STEP * c);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(MBX_CLR   + MBX_STEP * c);

    logic [NTMR-1:0]   tmr_en;
    logic              mbx_en;
    logic [DATA_W-1:0] mbox;
    logic [PEND_W-1:0] pend;
    logic              gpu_in;

    if (c == GPU_CORE) begin : g_gpu
      assign gpu_in = gpu_raw;
    end else begin : g_nogpu
      assign gpu_in = 1'b0;
    end

    cih_core #(.DATA_W(DATA_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_q),
      .wdata   (bus_wdata),
      .tc_we   (bus_we && bus_addr == A_TC),
      .mc_we   (bus_we && bus_addr == A_MC),
      .ms_we   (bus_we && bus_addr == A_MS),
      .mclr_we (bus_we && bus_addr == A_MCLR),
      .tmr_raw (timer_raw[c*NTMR +: NTMR]),
      .gpu_in  (gpu_in),
      .pmu_in  (route_q[c] & pmu_raw),
      .tmr_en  (tmr_en),
      .mbx_en  (mbx_en),
      .mbox    (mbox),
      .pend    (pend)
    );

    assign mbox_flat[c*DATA_W +: DATA_W] = mbox;
    assign pend_flat[c*PEND_W +: PEND_W] = pend;
    assign mbx_en_v[c]                   = mbx_en;
    assign irq_out[c]                    = |pend;

    always_comb begin
      if      (bus_addr == A_TC)   rd_c[c] = DATA_W'(tmr_en);
      else if (bus_addr == A_MC)   rd_c[c] = DATA_W'(mbx_en);
      else if (bus_addr == A_PD)   rd_c[c] = DATA_W'(pend);
      else if (bus_addr == A_MCLR) rd_c[c] = mbox;
      else                         rd_c[c] = '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_RSET || bus_addr == A_RCLR) bus_rdata = DATA_W'(route_q);
    for (int c = 0; c < NCORE; c++) bus_rdata = bus_rdata | rd_c[c];
  end
endmodule

// File: rtl/core_irq_hub_chk.sv
module core_irq_hub_chk
  import cih_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_we,
  input logic [DATA_W-1:0]       bus_wdata,
  input logic [NCORE*DATA_W-1:0] mbox_flat,
  input logic [NCORE*PEND_W-1:0] pend_flat,
  input logic [NCORE-1:0]        mbx_en_v,
  input logic [NCORE-1:0]        route_q
);
  a_r6_route_set: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == ADDR_W'(ROUTE_SET)) |=>
      ((route_q & $past(bus_wdata[NCORE-1:0])) == $past(bus_wdata[NCORE-1:0])));

  a_r6_route_clr: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == ADDR_W'(ROUTE_CLR)) |=>
      ((route_q & $past(bus_wdata[NCORE-1:0])) == '0));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_we |=> ($stable(route_q) && $stable(mbox_flat) && $stable(mbx_en_v)));

  for (genvar c = 0; c < NCORE; c++) begin : g_chk
    a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_q)
      (bus_we && bus_addr == ADDR_W'(MBX_SET + MBX_STEP * c)) |=>
        (mbox_flat[c*DATA_W +: DATA_W] ==
         ($past(mbox_flat[c*DATA_W +: DATA_W]) | $past(bus_wdata))));

    a_r3_clear_w1c: assert property (@(posedge clk) disable iff (!rst_q)
      (bus_we && bus_addr == ADDR_W'(MBX_CLR + MBX_STEP * c)) |=>
        (mbox_flat[c*DATA_W +: DATA_W] ==
         ($past(mbox_flat[c*DATA_W +: DATA_W]) & ~$past(bus_wdata))));

    a_r4_mbx_gate: assert property (@(posedge clk) disable iff (!rst_q)
      pend_flat[c*PEND_W + PB_MBX] |->
        (mbx_en_v[c] && mbox_flat[c*DATA_W +: DATA_W] != '0));
  end
endmodule

bind core_irq_hub core_irq_hub_chk #(.NCORE(NCORE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .mbox_flat (mbox_flat),
  .pend_flat (pend_flat),
  .mbx_en_v  (mbx_en_v),
  .route_q   (route_q)
);

// File: tb/tb_core_irq_hub.sv
`timescale 1ns/1ps
module tb_core_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] timer_raw;
  logic        gpu_raw;
  logic        pmu_raw;
  logic [3:0]  irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  core_irq_hub dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_raw(timer_raw),
    .gpu_raw(gpu_raw), .pmu_raw(pmu_raw), .irq_out(irq_out)
  );

  // Entry: [94:91] req, [90] write, [89:82] addr, [81:50] data,
  //        [49:32] src {pmu, gpu, timer[15:0]}, [31:0] expected read
  localparam int NV = 22;
  localparam logic [94:0] VEC [NV] = '{
    {4'd1, 1'b0, 8'h80, 32'h0,  18'h0,     32'h0},   // R1 mailbox 0 empty
    {4'd2, 1'b1, 8'h40, 32'h5,  18'h0,     32'h0},
    {4'd2, 1'b1, 8'h40, 32'h30, 18'h0,     32'h0},
    {4'd2, 1'b0, 8'h80, 32'h0,  18'h0,     32'h35},  // R2 OR of writes
    {4'd3, 1'b1, 8'h80, 32'h11, 18'h0,     32'h0},
    {4'd3, 1'b0, 8'h80, 32'h0,  18'h0,     32'h24},  // R3 bits 0,4 cleared
    {4'd4, 1'b0, 8'h30, 32'h0,  18'h0,     32'h0},   // R4 gated off
    {4'd4, 1'b1, 8'h20, 32'h1,  18'h0,     32'h0},
    {4'd4, 1'b0, 8'h30, 32'h0,  18'h0,     32'h10},  // R4 gate open
    {4'd5, 1'b1, 8'h10, 32'h5,  18'h0,     32'h0},
    {4'd5, 1'b0, 8'h30, 32'h0,  18'h0000F, 32'h15},  // R5 timers 0,2 only
    {4'd5, 1'b0, 8'h10, 32'h0,  18'h0,     32'h5},   // R5 enable readback
    {4'd6, 1'b1, 8'h00, 32'hA,  18'h0,     32'h0},
    {4'd6, 1'b0, 8'h3C, 32'h0,  18'h20000, 32'h40},  // R6 core 3 routed
    {4'd6, 1'b1, 8'h04, 32'h8,  18'h0,     32'h0},
    {4'd6, 1'b0, 8'h3C, 32'h0,  18'h20000, 32'h0},   // R6 core 3 unrouted
    {4'd6, 1'b0, 8'h34, 32'h0,  18'h20000, 32'h40},  // R6 core 1 kept
    {4'd6, 1'b0, 8'h04, 32'h0,  18'h0,     32'h2},   // R6 mask readback
    {4'd7, 1'b0, 8'h30, 32'h0,  18'h10000, 32'h30},  // R7 core 0 gets gpu
    {4'd7, 1'b0, 8'h38, 32'h0,  18'h10000, 32'h0},   // R7 core 2 does not
    {4'd9, 1'b1, 8'hFC, 32'hFFFFFFFF, 18'h0, 32'h0},
    {4'd9, 1'b0, 8'hFC, 32'h0,  18'h0,     32'h0}    // R9 unmapped
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 8'h0; bus_we = 1'b0; bus_wdata = 32'h0;
    timer_raw = 16'h0; gpu_raw = 1'b0; pmu_raw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {28'h0, irq_out}, 32'h0);
    rd("R1 pending core 0", 8'h30, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we    = VEC[i][90];
      bus_addr  = VEC[i][89:82];
      bus_wdata = VEC[i][81:50];
      {pmu_raw, gpu_raw, timer_raw} = VEC[i][49:32];
      if (!VEC[i][90]) begin
        #1 check($sformatf("R%0d vector %0d", VEC[i][94:91], i), bus_rdata, VEC[i][31:0]);
      end
    end
    @(negedge clk);
    bus_we = 1'b0; {pmu_raw, gpu_raw, timer_raw} = 18'h0;

    // R9: write to a pending word is ignored
    wr(8'h30, 32'hFFFFFFFF);
    rd("R9 pending write ignored", 8'h30, 32'h10);

    // R8: line follows the OR of pending, stays up until all causes clear
    #1 check("R8 mailbox drives line", {28'h0, irq_out}, 32'h1);
    timer_raw = 16'h0001;
    wr(8'h80, 32'hFFFFFFFF);
    #1 check("R8 timer keeps line up", {28'h0, irq_out}, 32'h1);
    rd("R3 mailbox fully cleared", 8'h80, 32'h0);
    timer_raw = 16'h0;
    #1 check("R8 line drops", {28'h0, irq_out}, 32'h0);

    // R2: mailbox stride per core, set address reads zero
    wr(8'h70, 32'h80000000);
    rd("R2 core 3 mailbox", 8'hB0, 32'h80000000);
    rd("R2 core 0 untouched", 8'h80, 32'h0);
    rd("R2 core 2 untouched", 8'hA0, 32'h0);
    rd("R2 set address reads zero", 8'h70, 32'h0);

    // R1: reset in the middle clears state
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 mailbox under reset", 0, 0);
    rd("R1 mailbox under reset", 8'hB0, 32'h0);
    rd("R1 route under reset", 8'h00, 32'h0);
    check("R1 irq under reset", {28'h0, irq_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd("R1 timer enable after reset", 8'h10, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule